// File: doc/BRIEF.md
# Crypto Register Access-Control Unit

This block holds a small bank of crypto registers. Each register has a data word and a 5-bit permission field. One command port carries every operation, and each command names a privilege level. High-security is `cmd_hs=1` and non-secure is `cmd_hs=0`. The operations are:

- store a memory word into a register;
- read a register back out to memory;
- ask whether a register may be used as a cipher key;
- fill a register from the secret store;
- rewrite a register's permission field.

The unit enforces the permission field on each of these. It also keeps the field internally consistent: some bits clear permanently once they are dropped, some bits force others on, and some bits force others off.

A command is captured on a clock edge. Its response is presented for exactly the following cycle by a response state machine, which has four states:

- `S_IDLE`: no response.
- `S_DONE`: the operation was granted.
- `S_REFUSED`: a key query was declined.
- `S_VIOLATE`: a load or store was blocked.

The next state is chosen from the incoming command alone:

- no valid command leads to `S_IDLE`;
- a granted operation, a secret fill or a permission write leads to `S_DONE`;
- a declined key query leads to `S_REFUSED`;
- a blocked load or store leads to `S_VIOLATE`.

Any state can move to any of the four on the next edge.

Permission field bits are numbered as follows:

| Bit | Meaning |
|-----|---------|
| 0 | key use at high security |
| 1 | read at high security |
| 2 | key use at non-secure |
| 3 | read at non-secure |
| 4 | write at non-secure |

Top module: `crypto_acl_unit`

## Requirements
- R1: After reset no response is valid (`rsp_valid=0`), and every register's permission field reads 0x1F, where bit 0 is high-security key use, bit 1 high-security read, bit 2 non-secure key use, bit 3 non-secure read and bit 4 non-secure write.
- R2: A store (op 1) at high security is always granted. It writes `cmd_data` into the register and returns the register's field to 0x1F.
- R3: A store at non-secure level is granted only when bit 4 is set, and it leaves the field as it is. A refused store raises `rsp_violation` and changes neither the data nor the field.
- R4: A load (op 2) is granted at high security when bit 1 is set, and at non-secure level when both bit 1 and bit 3 are set. A granted load returns the register data on `rsp_data`. A refused load returns zero and raises `rsp_violation` without `rsp_grant`.
- R5: A key query (op 3) is granted at high security when bit 0 is set, and at non-secure level when bit 2 is set. A declined query sets neither `rsp_grant` nor `rsp_violation`, and no query changes any state.
- R6: A secret fill (op 4) is granted at either level. It writes `sec_data` into the register and sets the field from the secret index `cmd_sec`:
  - index 1 gives 0x00;
  - otherwise, index mod 3 of 0, 1 and 2 gives 0x03, 0x01 and 0x00 respectively.
- R7: A permission write (op 5, new field in `cmd_data[4:0]`) cannot set bit 0 or bit 1 once that bit is clear. Only a high-security store, a secret fill or reset can set them again.
- R8: In a permission write, bit 3 is forced to 0 when the resulting bit 1 is 0, and bit 2 is forced to 0 when bit 0 is 0 after the sticky step. The order is sticky clears, then these forced clears, then the forced sets of R9.
- R9: In a permission write, bit 0 is forced to 1 when bit 1 is 1, and bit 2 is forced to 1 when bit 3 is 1.
- R10: Bit 4 follows the requested value freely. A clear bit 4 does not block a high-security store.
- R11: Each command of op 1 to 5 produces `rsp_valid` for exactly the next cycle, with `rsp_acl` showing the target's field after the operation. Op 0, 6 and 7 produce no response and change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_op | input | 3 | Operation code (0 none, 1 store, 2 load, 3 key query, 4 secret fill, 5 permission write) |
| cmd_hs | input | 1 | 1 for high-security level, 0 for non-secure |
| cmd_idx | input | IDX_W (3) | Target register |
| cmd_data | input | DATA_W (32) | Store data; bits 4:0 are the requested field for a permission write |
| cmd_sec | input | SEC_W (6) | Secret index for a secret fill |
| sec_data | input | DATA_W (32) | Secret value supplied by the secret store |
| rsp_valid | output | 1 | Response present this cycle |
| rsp_grant | output | 1 | Operation granted |
| rsp_violation | output | 1 | Load or store blocked |
| rsp_data | output | DATA_W (32) | Load data, zero otherwise |
| rsp_acl | output | 5 | Target register's field after the operation |

## Verification
The hardest situations to reach are the conflicting permission writes. They require a field that has already lost a sticky bit, followed by a request that asks for a bit the forcing rules must override.

The stimulus gets there in three steps:
1. It drives a register to 0x00 with a permission write.
2. It requests 0x1F, so the sticky step, the forced clears and the free bit 4 all act in the same edge.
3. It issues requests such as 0x06 and 0x0B, so a forced set and a forced clear meet in the same write.

Secret fills at several indices, including index 1 and the top index, then reseed fields that a permission write alone can no longer reach.

// File: rtl/cracl_pkg.sv
package cracl_pkg;
    localparam int ACL_W = 5;
    localparam logic [ACL_W-1:0] ACL_FULL = 5'h1F;

    localparam int B_SKEY  = 0;
    localparam int B_SRD   = 1;
    localparam int B_NKEY  = 2;
    localparam int B_NRD   = 3;
    localparam int B_NWR   = 4;

    typedef enum logic [2:0] {
        OP_NOP    = 3'd0,
        OP_STORE  = 3'd1,
        OP_LOAD   = 3'd2,
        OP_KEYQ   = 3'd3,
        OP_SECRET = 3'd4,
        OP_ACLWR  = 3'd5
    } op_e;

    typedef enum logic [1:0] {
        S_IDLE     = 2'd0,
        S_DONE     = 2'd1,
        S_REFUSED  = 2'd2,
        S_VIOLATE  = 2'd3
    } rsp_state_e;
endpackage

// File: rtl/acl_rule_apply.sv
module acl_rule_apply
    import cracl_pkg::*;
(
    input  logic [ACL_W-1:0] cur_acl,
    input  logic [ACL_W-1:0] req_acl,
    output logic [ACL_W-1:0] new_acl
);
    logic [ACL_W-1:0] sticky, cleared;

    always_comb begin
        // step 1: bits 0 and 1 may only stay set or fall
        sticky          = req_acl;
        sticky[B_SKEY]  = req_acl[B_SKEY] & cur_acl[B_SKEY];
        sticky[B_SRD]   = req_acl[B_SRD]  & cur_acl[B_SRD];
        // step 2: forced clears
        cleared         = sticky;
        cleared[B_NRD]  = sticky[B_NRD]  & sticky[B_SRD];
        cleared[B_NKEY] = sticky[B_NKEY] & sticky[B_SKEY];
        // step 3: forced sets
        new_acl         = cleared;
        new_acl[B_SKEY] = cleared[B_SKEY] | cleared[B_SRD];
        new_acl[B_NKEY] = cleared[B_NKEY] | cleared[B_NRD];
    end
endmodule

// File: rtl/secret_acl_lut.sv
module secret_acl_lut
    import cracl_pkg::*;
#(
    parameter int SEC_W = 6
) (
    input  logic [SEC_W-1:0] sec_idx,
    output logic [ACL_W-1:0] sec_acl
);
    localparam logic [SEC_W-1:0] IDX_ODD = SEC_W'(1);

    always_comb begin
        if (sec_idx == IDX_ODD) begin
            sec_acl = 5'h00;
        end else begin
            unique case (int'(sec_idx) % 3)
                0:       sec_acl = 5'h03;
                1:       sec_acl = 5'h01;
                default: sec_acl = 5'h00;
            endcase
        end
    end
endmodule

// File: rtl/acl_reg_bank.sv
module acl_reg_bank
    import cracl_pkg::*;
#(
    parameter int NREGS  = 8,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(NREGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  w_idx,
    input  logic              d_we,
    input  logic [DATA_W-1:0] d_in,
    input  logic              a_we,
    input  logic [ACL_W-1:0]  a_in,
    input  logic [IDX_W-1:0]  c_idx,
    output logic [DATA_W-1:0] c_data,
    output logic [ACL_W-1:0]  c_acl,
    input  logic [IDX_W-1:0]  r_idx,
    output logic [DATA_W-1:0] r_data,
    output logic [ACL_W-1:0]  r_acl
);
    logic [DATA_W-1:0] data_q [NREGS];
    logic [ACL_W-1:0]  acl_q  [NREGS];

    for (genvar i = 0; i < NREGS; i++) begin : g_reg
        logic hit;
        assign hit = (w_idx == IDX_W'(i));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                data_q[i] <= '0;
                acl_q[i]  <= ACL_FULL;
            end else begin
                if (d_we && hit) data_q[i] <= d_in;
                if (a_we && hit) acl_q[i]  <= a_in;
            end
        end

        AST_SRD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (!acl_q[i][B_SRD] && !(a_we && hit && a_in[B_SRD])) |=> !acl_q[i][B_SRD]); // R7
        AST_SRD_IMPLIES_SKEY: assert property (@(posedge clk) disable iff (!rst_n)
            acl_q[i][B_SRD] |-> acl_q[i][B_SKEY]); // R9
        AST_NRD_NEEDS_SRD: assert property (@(posedge clk) disable iff (!rst_n)
            acl_q[i][B_NRD] |-> (acl_q[i][B_SRD] && acl_q[i][B_NKEY])); // R8
        AST_NKEY_NEEDS_SKEY: assert property (@(posedge clk) disable iff (!rst_n)
            acl_q[i][B_NKEY] |-> acl_q[i][B_SKEY]); // R8
    end

    assign c_data = data_q[c_idx];
    assign c_acl  = acl_q[c_idx];
    assign r_data = data_q[r_idx];
    assign r_acl  = acl_q[r_idx];
endmodule

// File: rtl/crypto_acl_unit.sv
module crypto_acl_unit
    import cracl_pkg::*;
#(
    parameter int NREGS  = 8,
    parameter int DATA_W = 32,
    parameter int SEC_W  = 6,
    localparam int IDX_W = $clog2(NREGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cmd_op,
    input  logic              cmd_hs,
    input  logic [IDX_W-1:0]  cmd_idx,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic [SEC_W-1:0]  cmd_sec,
    input  logic [DATA_W-1:0] sec_data,
    output logic              rsp_valid,
    output logic              rsp_grant,
    output logic              rsp_violation,
    output logic [DATA_W-1:0] rsp_data,
    output logic [ACL_W-1:0]  rsp_acl
);
    rsp_state_e        state_q, state_d;
    op_e               op_q;
    logic [IDX_W-1:0]  idx_q;

    logic              d_we, a_we;
    logic [DATA_W-1:0] d_in;
    logic [ACL_W-1:0]  a_in;
    logic [DATA_W-1:0] c_data, r_data;
    logic [ACL_W-1:0]  c_acl, r_acl, sec_acl, wr_acl;
    logic              ok;

    secret_acl_lut #(.SEC_W(SEC_W)) u_lut (
        .sec_idx (cmd_sec),
        .sec_acl (sec_acl)
    );

    acl_rule_apply u_rules (
        .cur_acl (c_acl),
        .req_acl (cmd_data[ACL_W-1:0]),
        .new_acl (wr_acl)
    );

    acl_reg_bank #(.NREGS(NREGS), .DATA_W(DATA_W)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .w_idx  (cmd_idx),
        .d_we   (d_we),
        .d_in   (d_in),
        .a_we   (a_we),
        .a_in   (a_in),
        .c_idx  (cmd_idx),
        .c_data (c_data),
        .c_acl  (c_acl),
        .r_idx  (idx_q),
        .r_data (r_data),
        .r_acl  (r_acl)
    );

    // command decode and next-state selection
    always_comb begin
        ok      = 1'b0;
        d_we    = 1'b0;
        a_we    = 1'b0;
        d_in    = cmd_data;
        a_in    = ACL_FULL;
        state_d = S_IDLE;
        unique case (cmd_op)
            OP_STORE: begin
                ok      = cmd_hs | c_acl[B_NWR];
                d_we    = ok;
                a_we    = ok & cmd_hs;
                state_d = ok ? S_DONE : S_VIOLATE;
            end
            OP_LOAD: begin
                ok      = c_acl[B_SRD] & (cmd_hs | c_acl[B_NRD]);
                state_d = ok ? S_DONE : S_VIOLATE;
            end
            OP_KEYQ: begin
                ok      = cmd_hs ? c_acl[B_SKEY] : c_acl[B_NKEY];
                state_d = ok ? S_DONE : S_REFUSED;
            end
            OP_SECRET: begin
                d_we    = 1'b1;
                a_we    = 1'b1;
                d_in    = sec_data;
                a_in    = sec_acl;
                state_d = S_DONE;
            end
            OP_ACLWR: begin
                a_we    = 1'b1;
                a_in    = wr_acl;
                state_d = S_DONE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            op_q    <= OP_NOP;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            op_q    <= op_e'(cmd_op);
            idx_q   <= cmd_idx;
        end
    end

    // outputs from state
    always_comb begin
        rsp_valid     = 1'b0;
        rsp_grant     = 1'b0;
        rsp_violation = 1'b0;
        rsp_data      = '0;
        rsp_acl       = '0;
        unique case (state_q)
            S_IDLE: ;
            S_DONE: begin
                rsp_valid = 1'b1;
                rsp_grant = 1'b1;
                rsp_acl   = r_acl;
                if (op_q == OP_LOAD) rsp_data = r_data;
            end
            S_REFUSED: begin
                rsp_valid = 1'b1;
                rsp_acl   = r_acl;
            end
            S_VIOLATE: begin
                rsp_valid     = 1'b1;
                rsp_violation = 1'b1;
                rsp_acl       = r_acl;
            end
        endcase
    end

    AST_VIOL_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_violation |-> (rsp_data == '0 && !rsp_grant)); // R4
    AST_HS_STORE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op == OP_STORE && cmd_hs) |=> (rsp_grant && rsp_acl == ACL_FULL)); // R2
    AST_RESP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op inside {OP_STORE, OP_LOAD, OP_KEYQ, OP_SECRET, OP_ACLWR}) |=> rsp_valid); // R11
    AST_NOP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_op inside {OP_STORE, OP_LOAD, OP_KEYQ, OP_SECRET, OP_ACLWR}) |=> !rsp_valid); // R11
    AST_SECRET_GRANTED: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op == OP_SECRET) |=> (rsp_grant && !rsp_violation)); // R6
endmodule

// File: tb/tb_crypto_acl_unit.sv
module tb_crypto_acl_unit;
    localparam int NREGS  = 8;
    localparam int DATA_W = 32;
    localparam int SEC_W  = 6;
    localparam int IDX_W  = $clog2(NREGS);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [2:0]        cmd_op = 3'd0;
    logic              cmd_hs = 1'b0;
    logic [IDX_W-1:0]  cmd_idx = '0;
    logic [DATA_W-1:0] cmd_data = '0;
    logic [SEC_W-1:0]  cmd_sec = '0;
    logic [DATA_W-1:0] sec_data = '0;
    logic              rsp_valid, rsp_grant, rsp_violation;
    logic [DATA_W-1:0] rsp_data;
    logic [4:0]        rsp_acl;

    crypto_acl_unit #(.NREGS(NREGS), .DATA_W(DATA_W), .SEC_W(SEC_W)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .cmd_hs(cmd_hs),
        .cmd_idx(cmd_idx), .cmd_data(cmd_data), .cmd_sec(cmd_sec),
        .sec_data(sec_data), .rsp_valid(rsp_valid), .rsp_grant(rsp_grant),
        .rsp_violation(rsp_violation), .rsp_data(rsp_data), .rsp_acl(rsp_acl)
    );

    always #10 clk = ~clk;

    typedef struct {
        logic              grant;
        logic              viol;
        logic [DATA_W-1:0] data;
        logic [4:0]        acl;
        string             tag;
    } exp_t;

    exp_t              q[$];
    int                checks = 0;
    int                errors = 0;
    logic              mon_on = 1'b0;
    logic [DATA_W-1:0] m_data [NREGS];
    logic [4:0]        m_acl  [NREGS];

    task automatic check(input logic ok, input string tag, input string what,
                         input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [4:0] tbl(input int s);
        if (s == 1) return 5'h00;
        case (s % 3)
            0: return 5'h03;
            1: return 5'h01;
            default: return 5'h00;
        endcase
    endfunction

    function automatic logic [4:0] rule(input logic [4:0] o, input logic [4:0] r);
        logic b0, b1, b2, b3;
        b1 = r[1] & o[1];
        b0 = r[0] & o[0];
        b3 = r[3] & b1;
        b2 = r[2] & b0;
        b0 = b0 | b1;
        b2 = b2 | b3;
        return {r[4], b3, b2, b1, b0};
    endfunction

    // driver: applies a command and queues the expected response
    task automatic issue(input int op, input logic hs, input int idx,
                         input logic [DATA_W-1:0] d, input int sec,
                         input logic [DATA_W-1:0] sd, input string tag);
        exp_t e;
        @(negedge clk);
        cmd_op = 3'(op); cmd_hs = hs; cmd_idx = IDX_W'(idx);
        cmd_data = d; cmd_sec = SEC_W'(sec); sec_data = sd;
        e.grant = 1'b0; e.viol = 1'b0; e.data = '0; e.tag = tag;
        case (op)
            1: begin
                e.grant = hs || m_acl[idx][4];
                e.viol  = !e.grant;
                if (e.grant) begin
                    m_data[idx] = d;
                    if (hs) m_acl[idx] = 5'h1F;
                end
            end
            2: begin
                e.grant = m_acl[idx][1] && (hs || m_acl[idx][3]);
                e.viol  = !e.grant;
                if (e.grant) e.data = m_data[idx];
            end
            3: e.grant = hs ? m_acl[idx][0] : m_acl[idx][2];
            4: begin
                e.grant = 1'b1;
                m_acl[idx]  = tbl(sec);
                m_data[idx] = sd;
            end
            5: begin
                e.grant = 1'b1;
                m_acl[idx] = rule(m_acl[idx], d[4:0]);
            end
            default: ;
        endcase
        e.acl = m_acl[idx];
        if (op >= 1 && op <= 5) q.push_back(e);
    endtask

    task automatic idle();
        @(negedge clk);
        cmd_op = 3'd0;
    endtask

    // monitor: compares each response in the cycle after its command
    always @(posedge clk) begin
        #2;
        if (mon_on) begin
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                check(rsp_valid == 1'b1, e.tag, "valid", DATA_W'(rsp_valid), 1);
                check(rsp_grant == e.grant, e.tag, "grant", DATA_W'(rsp_grant), DATA_W'(e.grant));
                check(rsp_violation == e.viol, e.tag, "violation", DATA_W'(rsp_violation), DATA_W'(e.viol));
                check(rsp_data == e.data, e.tag, "data", rsp_data, e.data);
                check(rsp_acl == e.acl, e.tag, "acl", DATA_W'(rsp_acl), DATA_W'(e.acl));
            end else begin
                check(rsp_valid == 1'b0, "R11", "idle valid", DATA_W'(rsp_valid), 0);
            end
        end
    end

    initial begin
        #(20 * 20000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < NREGS; i++) begin
            m_data[i] = '0;
            m_acl[i]  = 5'h1F;
        end
        repeat (3) @(negedge clk);
        check(rsp_valid == 1'b0, "R1", "valid in reset", DATA_W'(rsp_valid), 0);
        rst_n = 1'b1;
        mon_on = 1'b1;
        // R1: every register starts at 0x1F
        for (int i = 0; i < NREGS; i++) issue(3, 1'b0, i, '0, 0, '0, "R1");
        idle();
        // R2: high-security store and read back
        issue(1, 1'b1, 0, 32'hA5A5_0001, 0, '0, "R2");
        issue(2, 1'b1, 0, '0, 0, '0, "R4");
        issue(2, 1'b0, 0, '0, 0, '0, "R4");
        // R7/R8: drop everything, then ask for everything back
        issue(5, 1'b0, 0, 32'h0000_0000, 0, '0, "R7");
        issue(1, 1'b0, 0, 32'h1111_1111, 0, '0, "R3");
        issue(2, 1'b0, 0, '0, 0, '0, "R4");
        issue(2, 1'b1, 0, '0, 0, '0, "R4");
        issue(3, 1'b1, 0, '0, 0, '0, "R5");
        issue(3, 1'b0, 0, '0, 0, '0, "R5");
        issue(5, 1'b1, 0, 32'h0000_001F, 0, '0, "R8");
        issue(1, 1'b0, 0, 32'h2222_2222, 0, '0, "R10");
        issue(1, 1'b1, 0, 32'h3333_3333, 0, '0, "R2");
        issue(2, 1'b0, 0, '0, 0, '0, "R2");
        // R9: forced sets
        issue(5, 1'b0, 1, 32'h0000_000B, 0, '0, "R9");
        issue(3, 1'b0, 1, '0, 0, '0, "R9");
        issue(5, 1'b0, 1, 32'h0000_0003, 0, '0, "R9");
        issue(2, 1'b0, 1, '0, 0, '0, "R4");
        issue(2, 1'b1, 1, '0, 0, '0, "R4");
        issue(3, 1'b0, 1, '0, 0, '0, "R5");
        issue(5, 1'b0, 1, 32'h0000_0006, 0, '0, "R8");
        issue(5, 1'b0, 1, 32'h0000_001D, 0, '0, "R7");
        issue(5, 1'b0, 1, 32'h0000_001F, 0, '0, "R7");
        // R10: bit 4 clear does not stop a high-security store
        issue(5, 1'b0, 3, 32'h0000_000F, 0, '0, "R10");
        issue(1, 1'b0, 3, 32'h4444_4444, 0, '0, "R10");
        issue(1, 1'b1, 3, 32'h5555_5555, 0, '0, "R10");
        issue(2, 1'b1, 3, '0, 0, '0, "R10");
        // R6: secret fills across the index pattern
        issue(4, 1'b0, 2, '0, 0,  32'hC0DE_0000, "R6");
        issue(2, 1'b1, 2, '0, 0, '0, "R6");
        issue(4, 1'b0, 2, '0, 1,  32'hC0DE_0001, "R6");
        issue(2, 1'b1, 2, '0, 0, '0, "R6");
        issue(4, 1'b1, 2, '0, 2,  32'hC0DE_0002, "R6");
        issue(4, 1'b0, 2, '0, 3,  32'hC0DE_0003, "R6");
        issue(4, 1'b0, 2, '0, 4,  32'hC0DE_0004, "R6");
        issue(3, 1'b1, 2, '0, 0, '0, "R5");
        issue(4, 1'b0, 2, '0, 5,  32'hC0DE_0005, "R6");
        issue(1, 1'b0, 2, 32'h6666_6666, 0, '0, "R3");
        issue(1, 1'b1, 2, 32'h7777_7777, 0, '0, "R2");
        issue(4, 1'b0, 7, '0, 63, 32'hC0DE_003F, "R6");
        issue(2, 1'b1, 7, '0, 0, '0, "R6");
        // R11: unused opcodes change nothing and answer nothing
        issue(6, 1'b1, 7, 32'hFFFF_FFFF, 0, '0, "R11");
        issue(7, 1'b1, 7, 32'h0, 0, '0, "R11");
        idle();
        issue(2, 1'b1, 7, '0, 0, '0, "R11");
        idle();
        idle();
        idle();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule